// File: doc/BRIEF.md
# Format-Tagged Floating-Point Register File

This block is the register store of a floating-point coprocessor. It holds 32 registers and keeps a small format tag beside each. The tag records how the register was last written or first read: single, double, word, long, uninterpreted, or unknown. Every access is checked against that tag. A read in a format that clashes with the tag poisons the tag to unknown and returns a quiet NaN that suits the requested format.

A mode input selects the register geometry. With `mode64` high, every register is 64 bits wide. With `mode64` low, registers are 32 bits wide, and a 64-bit value lives in an even/odd pair. The even register holds the low half and the next register holds the high half. A 64-bit access to an odd index in that mode raises a reserved-instruction strobe. An unrecognised format code raises a format-fault strobe.

The block has one read port and one write port. Read data is combinational. Tag changes caused by a read are registered on the clock edge of the enabled cycle.

Top module: `fpr_tagfile`

## Requirements
- R1: After reset every tag is uninterpreted and every register holds zero, so an uninterpreted read returns 0 with no strobe. In paired mode an odd index is the exception: that read raises the reserved-instruction strobe.
- R2: Format codes are 0 single, 1 double, 2 word, 3 long, 4 uninterpreted, 5 uninterpreted-32, 6 uninterpreted-64 and 7 unrecognised. A read with code 4 is served in the register's current tag. A register tagged uninterpreted adopts the requested read format, and that new tag stays in place for later accesses.
- R3: If the effective read format differs from the tag after adoption, the tag becomes unknown. A read of an unknown-tagged register returns a quiet NaN chosen by the requested format:
  - single: 0x7FBFFFFF
  - word: 0x7FFFFFFF
  - double: 0x7FF7FFFF_FFFFFFFF
  - long: 0x7FFFFFFF_FFFFFFFF
- R4: With `mode64` high, a single or word read returns the low 32 bits, zero-extended. A double, long or uninterpreted read returns all 64 bits.
- R5: With `mode64` low, a 64-bit read at even index n returns register n+1 in bits 63:32 and register n in bits 31:0. At an odd index it returns 0 and pulses `rsvd_exc`, unless the tag check has already made that register unknown.
- R6: With `mode64` high, a 32-bit write (codes 0, 2 or 5) stores the value in the low half and 0xDEADC0DE in the upper half. The tag becomes the written format, with code 5 recorded as uninterpreted.
- R7: With `mode64` high, a 64-bit write (codes 1, 3, 4 or 6) stores all 64 bits. The tag becomes the written format, with code 6 recorded as uninterpreted.
- R8: With `mode64` low, a 32-bit write stores the low 32 bits, clears the upper bits and sets the tag.
- R9: With `mode64` low, a 64-bit write to an even index n puts bits 63:32 in register n+1 and bits 31:0 in register n, and tags both. A 64-bit write to an odd index changes no data. It sets the tag of n, and of n+1 if that register exists, to unknown, and it pulses `rsvd_exc`.
- R10: A write with code 7 leaves the data unchanged, tags the target unknown and pulses `fmt_fault`. A read with code 5, 6 or 7 returns 0, leaves the tag unchanged and pulses `fmt_fault`. So does an uninterpreted read of an unknown-tagged register.
- R11: A read and a write in the same cycle see the pre-write contents. When both change the same tag, the write's tag wins.
- R12: `rsvd_exc` and `fmt_fault` are high only in the cycle the offending access is enabled, and are low when neither port is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode64 | input | 1 | 1: 64-bit registers; 0: 32-bit registers paired for 64-bit values |
| rd_en | input | 1 | Read enable |
| rd_idx | input | 5 | Read register index |
| rd_fmt | input | 3 | Requested read format code |
| rd_data | output | 64 | Read value (0 when idle, faulted or excepted) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_fmt | input | 3 | Write format code |
| wr_data | input | 64 | Write value |
| rsvd_exc | output | 1 | Reserved-instruction strobe (odd-index 64-bit access in paired mode) |
| fmt_fault | output | 1 | Unrecognised-format strobe |

## Verification
Internal state appears at the ports only through the next read of the register concerned. A wrong tag therefore shows up as a quiet NaN where a value was due, or as a value where a NaN was due. A tag that fails to adopt or to poison shows on the following read of that index, one cycle later at the earliest. A misplaced half of a paired write, or a missing filler word, shows only on a read in the matching width. For that reason the sweeps follow each write pass with reads of every index in every format code, under both modes.

// File: rtl/fpr_tagfile.sv
module fpr_tagfile #(
  parameter int NREG = 32,
  parameter int IW = $clog2(NREG),
  parameter logic [31:0] FILL = 32'hDEADC0DE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode64,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  input  logic [2:0]    rd_fmt,
  output logic [63:0]   rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [2:0]    wr_fmt,
  input  logic [63:0]   wr_data,
  output logic          rsvd_exc,
  output logic          fmt_fault
);
  localparam logic [2:0] F_SGL = 3'd0, F_DBL = 3'd1, F_WRD = 3'd2, F_LNG = 3'd3;
  localparam logic [2:0] F_UNI = 3'd4, F_U32 = 3'd5, F_U64 = 3'd6, F_BAD = 3'd7;
  localparam logic [2:0] T_UNK = 3'd5;
  localparam logic [IW-1:0] LAST = IW'(NREG - 1);

  logic [63:0] data_q [NREG];
  logic [2:0]  tag_q  [NREG];

  // read side: effective format, adoption, poisoning
  logic [2:0] rtag, eff, adopt, rtag_new;
  logic       rd_fmt_ok, eff_wide, rd_exc, rd_flt;
  logic [IW-1:0] rd_hi;

  assign rtag      = tag_q[rd_idx];
  assign rd_fmt_ok = rd_fmt <= F_UNI;
  assign eff       = (rd_fmt == F_UNI) ? rtag : rd_fmt;
  assign adopt     = (rtag == F_UNI) ? eff : rtag;
  assign rtag_new  = (eff != adopt) ? T_UNK : adopt;
  assign eff_wide  = (eff == F_DBL) || (eff == F_LNG) || (eff == F_UNI);
  assign rd_hi     = rd_idx | IW'(1);

  always_comb begin
    rd_data = '0;
    rd_exc  = 1'b0;
    rd_flt  = 1'b0;
    if (rd_en) begin
      if (!rd_fmt_ok) rd_flt = 1'b1;
      else if (rtag_new == T_UNK) begin
        case (eff)
          F_SGL:   rd_data = 64'h0000_0000_7FBF_FFFF;
          F_WRD:   rd_data = 64'h0000_0000_7FFF_FFFF;
          F_DBL:   rd_data = 64'h7FF7_FFFF_FFFF_FFFF;
          F_LNG:   rd_data = 64'h7FFF_FFFF_FFFF_FFFF;
          default: rd_flt  = 1'b1;
        endcase
      end
      else if (!eff_wide) rd_data = {32'h0, data_q[rd_idx][31:0]};
      else if (mode64)    rd_data = data_q[rd_idx];
      else if (rd_idx[0]) rd_exc  = 1'b1;
      else                rd_data = {data_q[rd_hi][31:0], data_q[rd_idx][31:0]};
    end
  end

  // write side
  logic       w_narrow, w_pair_bad, w_flt;
  logic [2:0] w_tag;
  logic [IW-1:0] wr_nxt;

  assign w_narrow   = (wr_fmt == F_SGL) || (wr_fmt == F_WRD) || (wr_fmt == F_U32);
  assign w_tag      = ((wr_fmt == F_U32) || (wr_fmt == F_U64)) ? F_UNI : wr_fmt;
  assign w_flt      = wr_en && (wr_fmt == F_BAD);
  assign w_pair_bad = wr_en && !mode64 && !w_narrow && !w_flt && wr_idx[0];
  assign wr_nxt     = wr_idx + IW'(1);

  assign rsvd_exc  = rd_exc | w_pair_bad;
  assign fmt_fault = rd_flt | w_flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        data_q[i] <= '0;
        tag_q[i]  <= F_UNI;
      end
    end else begin
      if (rd_en && rd_fmt_ok) tag_q[rd_idx] <= rtag_new;
      if (wr_en) begin
        if (wr_fmt == F_BAD) tag_q[wr_idx] <= T_UNK;
        else if (w_narrow) begin
          data_q[wr_idx] <= {mode64 ? FILL : 32'h0, wr_data[31:0]};
          tag_q[wr_idx]  <= w_tag;
        end
        else if (mode64) begin
          data_q[wr_idx] <= wr_data;
          tag_q[wr_idx]  <= w_tag;
        end
        else if (!wr_idx[0]) begin
          data_q[wr_idx] <= {32'h0, wr_data[31:0]};
          data_q[wr_nxt] <= {32'h0, wr_data[63:32]};
          tag_q[wr_idx]  <= w_tag;
          tag_q[wr_nxt]  <= w_tag;
        end
        else begin
          tag_q[wr_idx] <= T_UNK;
          if (wr_idx != LAST) tag_q[wr_nxt] <= T_UNK;
        end
      end
    end
  end

  p_exc_paired_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_exc |-> !mode64);

  p_poison_on_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && rd_fmt == F_SGL && tag_q[rd_idx] == F_DBL)
    |=> tag_q[$past(rd_idx)] == T_UNK);

  p_filler_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode64 && wr_fmt == F_SGL) |=> data_q[$past(wr_idx)][63:32] == FILL);

  p_pair_high_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mode64 && wr_fmt == F_DBL && !wr_idx[0])
    |=> data_q[$past(wr_idx) | IW'(1)][31:0] == $past(wr_data[63:32]));

  p_fault_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_fmt_ok) |-> (fmt_fault && rd_data == 64'h0));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |-> (!rsvd_exc && !fmt_fault));
endmodule

// File: tb/fpr_tagfile_tb.sv
module fpr_tagfile_tb;
  logic clk = 1'b0, rst_n = 1'b0, mode64 = 1'b1;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [4:0] rd_idx = '0, wr_idx = '0;
  logic [2:0] rd_fmt = '0, wr_fmt = '0;
  logic [63:0] wr_data = '0, rd_data;
  logic rsvd_exc, fmt_fault;

  int checks = 0, failures = 0;
  bit [63:0] m_dat [32];
  int        m_tag [32];

  always #5 clk = ~clk;

  fpr_tagfile u_dut (.clk(clk), .rst_n(rst_n), .mode64(mode64),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_fmt(rd_fmt), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_fmt(wr_fmt), .wr_data(wr_data),
    .rsvd_exc(rsvd_exc), .fmt_fault(fmt_fault));

  task automatic chk(input string req, input bit [63:0] act, input bit [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 32; i++) begin m_dat[i] = '0; m_tag[i] = 4; end
  endtask

  // one cycle with optional read and write; expected values from the requirements
  task automatic op(input bit ren, input int ri, input int rf,
                    input bit wen, input int wi, input int wf, input bit [63:0] wd,
                    input string rq);
    bit [63:0] ed = '0;
    bit ex = 0, ef = 0;
    int t = 0, eff = 0;
    string dreq = rq;
    @(negedge clk);
    rd_en = ren; rd_idx = 5'(ri); rd_fmt = 3'(rf);
    wr_en = wen; wr_idx = 5'(wi); wr_fmt = 3'(wf); wr_data = wd;
    #1;
    if (ren) begin
      if (rf > 4) begin ef = 1; dreq = "R10"; end
      else begin
        t = m_tag[ri];
        eff = (rf == 4) ? t : rf;
        if (t == 4) t = eff;
        if (t != eff) t = 5;
        if (t == 5) begin
          dreq = "R3";
          case (eff)
            0: ed = 64'h7FBFFFFF;
            2: ed = 64'h7FFFFFFF;
            1: ed = 64'h7FF7FFFF_FFFFFFFF;
            3: ed = 64'h7FFFFFFF_FFFFFFFF;
            default: begin ef = 1; dreq = "R10"; end
          endcase
        end
        else if (eff == 0 || eff == 2) begin ed = {32'h0, m_dat[ri][31:0]}; dreq = "R4"; end
        else if (mode64) begin ed = m_dat[ri]; dreq = "R4"; end
        else if (ri % 2 == 1) begin ex = 1; dreq = "R5"; end
        else begin ed = {m_dat[ri+1][31:0], m_dat[ri][31:0]}; dreq = "R5"; end
      end
    end
    if (wen) begin
      if (wf == 7) ef = 1;
      else if (!mode64 && !(wf == 0 || wf == 2 || wf == 5) && wi % 2 == 1) ex = 1;
    end
    chk({dreq, " ", rq, " rd_data"}, rd_data, ed);
    chk({"R5 R9 ", rq, " rsvd_exc"}, 64'(rsvd_exc), 64'(ex));
    chk({"R10 ", rq, " fmt_fault"}, 64'(fmt_fault), 64'(ef));
    // model update: read tag first, write overrides (R11)
    if (ren && rf <= 4) m_tag[ri] = t;
    if (wen) begin
      if (wf == 7) m_tag[wi] = 5;
      else if (wf == 0 || wf == 2 || wf == 5) begin
        m_dat[wi] = {mode64 ? 32'hDEADC0DE : 32'h0, wd[31:0]};
        m_tag[wi] = (wf == 5) ? 4 : wf;
      end
      else if (mode64) begin m_dat[wi] = wd; m_tag[wi] = (wf == 6) ? 4 : wf; end
      else if (wi % 2 == 0) begin
        m_dat[wi] = {32'h0, wd[31:0]}; m_dat[wi+1] = {32'h0, wd[63:32]};
        m_tag[wi] = (wf == 6) ? 4 : wf; m_tag[wi+1] = m_tag[wi];
      end
      else begin m_tag[wi] = 5; if (wi < 31) m_tag[wi+1] = 5; end
    end
    @(posedge clk);
    #1 rd_en = 1'b0; wr_en = 1'b0;
    #1;
    chk("R12 strobes idle", {62'h0, rsvd_exc, fmt_fault}, 64'h0);
  endtask

  function automatic bit [63:0] pat(input int i, input int f);
    return {8'hC3, 8'(f), 8'(i), 8'h5A, 8'h3C, 8'(i), 8'(f), 8'hA5};
  endfunction

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int m = 1; m >= 0; m--) begin
      mode64 = m[0];
      do_reset();
      for (int i = 0; i < 32; i++) op(1, i, 4, 0, 0, 0, 0, "R1 reset");
      for (int wf = 0; wf < 8; wf++) begin
        do_reset();
        for (int i = 0; i < 32; i++) op(0, 0, 0, 1, i, wf, pat(i, wf), "R6 R7 R8 R9 write");
        for (int rf = 0; rf < 8; rf++)
          for (int i = 0; i < 32; i++) op(1, i, rf, 0, 0, 0, 0, "R2 sweep read");
      end
      do_reset();
      for (int i = 0; i < 32; i++) op(1, i, (i % 4), 0, 0, 0, 0, "R2 adopt");
      for (int i = 0; i < 32; i++) op(1, i, 4, 0, 0, 0, 0, "R2 adopted tag");
      for (int i = 0; i < 32; i++) op(1, i, ((i + 1) % 4), 0, 0, 0, 0, "R3 clash");
      for (int i = 0; i < 32; i++) op(1, i, 4, 0, 0, 0, 0, "R10 uni on unknown");
      do_reset();
      for (int i = 0; i < 32; i++) op(1, i, 0, 1, i, 1, pat(i, 9), "R11 same cycle");
      for (int i = 0; i < 32; i++) op(1, i, 1, 1, (i + 5) % 32, 2, pat(i, 8), "R11 mixed");
      for (int i = 0; i < 32; i++) op(1, i, 1, 0, 0, 0, 0, "R11 after");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule